// File: doc/BRIEF.md
# Bit Count And Swap Unit

This unit is a small execution slice for bit-level operations on an operand of selectable size. A caller presents an operand, an accumulator value, a size code and an operation code, then pulses `start`. One clock later `done` pulses and the registered result, the result write enable, and three flag values (zero, negative, overflow), each with its own write enable, are valid. The flag enables tell the surrounding datapath which flags to update. Only the enables that belong to the operation in that cycle are raised.

The operations are:

- Counting the leading zeros or leading ones of a field whose width comes from the size code.
- Exchanging the two halves of a size-masked operand around a split point that depends on the size.
- Counting the set bits of the full operand.
- A bit test that loads flags from fixed operand bits and from the AND with the accumulator. The bit test writes no result.

There is no back-pressure. The unit accepts a `start` in every cycle, including back-to-back cycles. Each `start` produces exactly one `done`, one cycle later. Between operations the `result` and flag value outputs hold their last values, and every write enable is low.

Top module: `bcs_unit`

## Requirements
- R1: `done` is high in the cycle after each cycle in which `start` is sampled high, and low in every other cycle, including back-to-back starts.
- R2: With op code 0 (count leading zeros), the field width is min(size,8)*8 bits, taken from the low end of the operand. Bits above the field are ignored. The result is the number of consecutive zero bits counted downward from the top bit of the field.
- R3: With op code 1 (count leading ones), the same field rule applies, and the result is the number of consecutive one bits counted downward from the top bit of the field.
- R4: When every bit of the field equals the counted polarity, the count is the field width. This includes width 0 for a size code of 0, which yields 0.
- R5: For op codes 0 and 1, only the zero flag is written, and it is set exactly when the count is 0. The result write enable is high.
- R6: With op code 2 (half swap), s = min(size,7), h = 0 when s < 2 and ((s-1)*8)/2 otherwise, and m = the low (s+1)*8 bits set. The result is ((x>>h) & (m>>h)) | ((x<<h) & (m<<h) & m). No flag is written.
- R7: With op code 3 (population count), the result is the number of set bits in the whole operand, independent of the size code. No flag is written.
- R8: With op code 4 (bit test), negative takes operand bit 7, overflow takes operand bit 6, and zero is set when (accumulator AND operand) is zero. All three flag enables are high. The result write enable is low and the result reads 0.
- R9: Op codes 5 to 7 produce `done` with every write enable low and the result and flags reading 0.
- R10: After reset, `done`, the result, all flags and all write enables are 0.
- R11: Every write enable is low in any cycle where `done` is low. In those cycles the result and flag values keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the inputs of this cycle |
| op | input | 3 | Operation code (0 lead zeros, 1 lead ones, 2 half swap, 3 population count, 4 bit test) |
| size | input | SIZE_W (4) | Byte-size code, clamped per operation |
| operand | input | DATA_W (64) | Operand value |
| acc | input | DATA_W (64) | Accumulator value for the bit test |
| done | output | 1 | One-cycle pulse, one cycle after `start` |
| result | output | DATA_W (64) | Operation result |
| result_we | output | 1 | Result is to be written |
| flag_z | output | 1 | Zero flag value |
| flag_z_we | output | 1 | Zero flag write enable |
| flag_n | output | 1 | Negative flag value |
| flag_n_we | output | 1 | Negative flag write enable |
| flag_v | output | 1 | Overflow flag value |
| flag_v_we | output | 1 | Overflow flag write enable |

## Verification
The bench targets four groups of cases, each tied to a likely fault.

- **Leading counts.** The bench applies all-equal fields and a size code of 0. It also applies size codes above 8 and operands whose set bits lie above a narrow field. A design that counted on the full 64 bits, failed to clamp the size, or stopped one bit early would return the wrong count or miss the zero flag.
- **Half swap.** The bench sweeps size codes 0 through 9. A wrong split point or mask, or a missing clamp at 7, shows up as a wrong result.
- **Bit test and reserved codes.** These cases confirm that no result enable leaks out. They also confirm that a flag is taken from the correct bit, since a design reading the wrong bit would swap negative and overflow.
- **Start timing.** Back-to-back and isolated starts expose a done pulse that is stretched or lost.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LZ    = 3'd0,
    OP_LO    = 3'd1,
    OP_SWAP  = 3'd2,
    OP_POPC  = 3'd3,
    OP_BTEST = 3'd4
  } bcs_op_e;

  // bit positions copied into flags by the bit test
  localparam int BTEST_N_BIT = 7;
  localparam int BTEST_V_BIT = 6;
endpackage

// File: rtl/bcs_lead_count.sv
module bcs_lead_count #(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              polarity,
  input  logic [SIZE_W-1:0] size,
  output logic [CNT_W-1:0]  count
);
  localparam int MAX_BYTES = DATA_W / 8;

  logic [SIZE_W-1:0] bytes;
  logic [DATA_W-1:0] norm;
  logic              run;
  int                width;

  always_comb begin
    bytes = (size > SIZE_W'(MAX_BYTES)) ? SIZE_W'(MAX_BYTES) : size;
    width = 8 * int'(bytes);
    // counting ones is counting zeros of the complement
    norm  = polarity ? ~operand : operand;
    count = '0;
    run   = 1'b1;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (i < width) begin
        if (run && !norm[i]) count = count + CNT_W'(1);
        else                 run   = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcs_half_swap.sv
module bcs_half_swap #(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [SIZE_W-1:0] size,
  output logic [DATA_W-1:0] swapped
);
  localparam int MAX_CODE = DATA_W / 8 - 1;

  logic [SIZE_W-1:0] code;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] low_part;
  logic [DATA_W-1:0] high_part;
  int                split;

  always_comb begin
    code      = (size > SIZE_W'(MAX_CODE)) ? SIZE_W'(MAX_CODE) : size;
    split     = (code < SIZE_W'(2)) ? 0 : ((int'(code) - 1) * 8) / 2;
    mask      = {DATA_W{1'b1}} >> (8 * (MAX_CODE - int'(code)));
    low_part  = (operand >> split) & (mask >> split);
    high_part = (operand << split) & (mask << split) & mask;
    swapped   = low_part | high_part;
  end
endmodule

// File: rtl/bcs_popcount.sv
module bcs_popcount #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] operand,
  output logic [CNT_W-1:0]  ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) ones = ones + CNT_W'(operand[i]);
  end
endmodule

// File: rtl/bcs_unit.sv
module bcs_unit
  import bcs_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] acc,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic              flag_z,
  output logic              flag_z_we,
  output logic              flag_n,
  output logic              flag_n_we,
  output logic              flag_v,
  output logic              flag_v_we
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0]  lead_cnt;
  logic [CNT_W-1:0]  pop_cnt;
  logic [DATA_W-1:0] swap_val;

  bcs_lead_count #(.DATA_W(DATA_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_lead (
    .operand (operand),
    .polarity(op == OP_LO),
    .size    (size),
    .count   (lead_cnt)
  );

  bcs_half_swap #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_swap (
    .operand(operand),
    .size   (size),
    .swapped(swap_val)
  );

  bcs_popcount #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_pop (
    .operand(operand),
    .ones   (pop_cnt)
  );

  logic [DATA_W-1:0] nx_res;
  logic              nx_res_we, nx_z, nx_z_we, nx_n, nx_n_we, nx_v, nx_v_we;

  always_comb begin
    nx_res    = '0;
    nx_res_we = 1'b0;
    nx_z      = 1'b0;
    nx_z_we   = 1'b0;
    nx_n      = 1'b0;
    nx_n_we   = 1'b0;
    nx_v      = 1'b0;
    nx_v_we   = 1'b0;
    case (op)
      OP_LZ, OP_LO: begin
        nx_res    = DATA_W'(lead_cnt);
        nx_res_we = 1'b1;
        nx_z      = (lead_cnt == '0);
        nx_z_we   = 1'b1;
      end
      OP_SWAP: begin
        nx_res    = swap_val;
        nx_res_we = 1'b1;
      end
      OP_POPC: begin
        nx_res    = DATA_W'(pop_cnt);
        nx_res_we = 1'b1;
      end
      OP_BTEST: begin
        nx_n    = operand[BTEST_N_BIT];
        nx_v    = operand[BTEST_V_BIT];
        nx_z    = ((acc & operand) == '0);
        nx_n_we = 1'b1;
        nx_v_we = 1'b1;
        nx_z_we = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      result    <= '0;
      result_we <= 1'b0;
      flag_z    <= 1'b0;
      flag_z_we <= 1'b0;
      flag_n    <= 1'b0;
      flag_n_we <= 1'b0;
      flag_v    <= 1'b0;
      flag_v_we <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result    <= nx_res;
        result_we <= nx_res_we;
        flag_z    <= nx_z;
        flag_z_we <= nx_z_we;
        flag_n    <= nx_n;
        flag_n_we <= nx_n_we;
        flag_v    <= nx_v;
        flag_v_we <= nx_v_we;
      end else begin
        result_we <= 1'b0;
        flag_z_we <= 1'b0;
        flag_n_we <= 1'b0;
        flag_v_we <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcs_unit_chk.sv
module bcs_unit_chk
  import bcs_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        op,
  input logic [SIZE_W-1:0] size,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] acc,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic              result_we,
  input logic              flag_z,
  input logic              flag_z_we,
  input logic              flag_n,
  input logic              flag_n_we,
  input logic              flag_v,
  input logic              flag_v_we
);
  // R1
  start_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R1
  done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  // R11
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(result_we || flag_z_we || flag_n_we || flag_v_we));

  // R5
  lead_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($past(op) == 3'(OP_LZ) || $past(op) == 3'(OP_LO)))
      |-> (flag_z_we && !flag_n_we && !flag_v_we && result_we
           && (flag_z == (result == '0))));

  // R4
  lead_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($past(op) == 3'(OP_LZ) || $past(op) == 3'(OP_LO)))
      |-> (result <= DATA_W'(DATA_W)));

  // R7
  popc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(op) == 3'(OP_POPC))
      |-> (result_we && !flag_z_we && !flag_n_we && !flag_v_we));

  // R8
  btest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(op) == 3'(OP_BTEST))
      |-> (!result_we && flag_n == $past(operand[BTEST_N_BIT])
           && flag_v == $past(operand[BTEST_V_BIT])
           && flag_z == (($past(acc) & $past(operand)) == '0)));

  // R9
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(op) > 3'(OP_BTEST))
      |-> !(result_we || flag_z_we || flag_n_we || flag_v_we));
endmodule

bind bcs_unit bcs_unit_chk #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/tb_bcs_unit.sv
module tb_bcs_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        done;
    logic [63:0] res;
    logic        res_we;
    logic        z, z_we, n, n_we, v, v_we;
  } obs_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [3:0]  size = '0;
  logic [63:0] operand = '0;
  logic [63:0] acc = '0;
  logic        done, result_we, flag_z, flag_z_we, flag_n, flag_n_we, flag_v, flag_v_we;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcs_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
    .operand(operand), .acc(acc), .done(done), .result(result),
    .result_we(result_we), .flag_z(flag_z), .flag_z_we(flag_z_we),
    .flag_n(flag_n), .flag_n_we(flag_n_we), .flag_v(flag_v), .flag_v_we(flag_v_we)
  );

  // reference: leading run length (R2, R3, R4)
  function automatic int ref_lead(logic [63:0] x, logic pol, int sz);
    int bytes = (sz > 8) ? 8 : sz;
    int n = 0;
    for (int i = bytes * 8 - 1; i >= 0; i--) begin
      if (x[i] !== pol) break;
      n++;
    end
    return n;
  endfunction

  // reference: half swap (R6)
  function automatic logic [63:0] ref_swap(logic [63:0] x, int sz);
    int s = (sz > 7) ? 7 : sz;
    int h = (s < 2) ? 0 : ((s - 1) * 8) / 2;
    logic [63:0] m = (s == 7) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ((s + 1) * 8)) - 64'd1);
    return ((x >> h) & (m >> h)) | ((x << h) & (m << h) & m);
  endfunction

  // reference: set-bit count (R7)
  function automatic int ref_pop(logic [63:0] x);
    int c = 0;
    logic [63:0] t = x;
    while (t != 0) begin
      t = t & (t - 64'd1);
      c++;
    end
    return c;
  endfunction

  function automatic obs_t ref_op(logic [2:0] o, int sz, logic [63:0] x, logic [63:0] a);
    obs_t r = '0;
    int c;
    r.done = 1'b1;
    case (o)
      3'd0, 3'd1: begin
        c = ref_lead(x, o[0], sz);
        r.res = 64'(c); r.res_we = 1'b1; r.z = (c == 0); r.z_we = 1'b1;
      end
      3'd2: begin r.res = ref_swap(x, sz); r.res_we = 1'b1; end
      3'd3: begin r.res = 64'(ref_pop(x)); r.res_we = 1'b1; end
      3'd4: begin
        r.n = x[7]; r.v = x[6]; r.z = ((a & x) == 64'd0);
        r.n_we = 1'b1; r.v_we = 1'b1; r.z_we = 1'b1;
      end
      default: ;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  // cycle model, updated at each rising edge; inputs change only at falling edges
  obs_t       model = '0;
  logic [2:0] model_op = '0;
  logic       armed = 1'b0;

  always @(posedge clk) begin
    armed = 1'b1;
    if (!rst_n) begin
      model = '0;
    end else if (start) begin
      model = ref_op(op, int'(size), operand, acc);
      model_op = op;
    end else begin
      model.done = 1'b0;
      model.res_we = 1'b0;
      model.z_we = 1'b0;
      model.n_we = 1'b0;
      model.v_we = 1'b0;
    end
  end

  obs_t seen;
  always_comb seen = '{done, result, result_we, flag_z, flag_z_we, flag_n, flag_n_we, flag_v, flag_v_we};

  always @(negedge clk) begin
    if (armed) begin
      string t;
      checks++;
      if (seen !== model) begin
        errors++;
        if (!rst_n) t = "R10";
        else if (seen.done !== model.done) t = "R1";
        else if (!model.done) t = "R11";
        else t = tag_of(model_op);
        $display("FAIL %s: outputs got %h exp %h", t, seen, model);
      end
    end
  end

  task automatic check_val(string t, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", t, got, exp);
    end
  endtask

  task automatic run_op(logic [2:0] o, int sz, logic [63:0] x, logic [63:0] a);
    @(negedge clk);
    op = o; size = 4'(sz); operand = x; acc = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got hang exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check_val("R10", {63'd0, done}, 64'd0);
    check_val("R10", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 counts within the field, bits above ignored, size clamp
    run_op(3'd0, 8, 64'h0000_F000_0000_0000, 0); check_val("R2", result, 64'd16);
    run_op(3'd0, 2, 64'hFFFF_FFFF_FFFF_0080, 0); check_val("R2", result, 64'd8);
    run_op(3'd0, 12, 64'h0100_0000_0000_0000, 0); check_val("R2", result, 64'd7);
    // R4 all-equal fields
    run_op(3'd0, 8, 64'd0, 0); check_val("R4", result, 64'd64);
    run_op(3'd0, 3, 64'hFFFF_FFFF_FF00_0000, 0); check_val("R4", result, 64'd24);
    run_op(3'd1, 8, 64'hFFFF_FFFF_FFFF_FFFF, 0); check_val("R4", result, 64'd64);
    // R5 zero count sets Z
    run_op(3'd0, 0, 64'h1234, 0); check_val("R5", {63'd0, flag_z}, 64'd1);
    run_op(3'd0, 8, 64'h8000_0000_0000_0000, 0); check_val("R5", {63'd0, flag_z}, 64'd1);
    // R3 leading ones
    run_op(3'd1, 4, 64'h0000_0000_F0FF_FFFF, 0); check_val("R3", result, 64'd4);
    run_op(3'd1, 8, 64'h7FFF_FFFF_FFFF_FFFF, 0); check_val("R3", result, 64'd0);
    // R6 swap across every size code incl. clamped ones
    for (int s = 0; s < 10; s++) begin
      run_op(3'd2, s, 64'h1122_3344_5566_7788, 0);
      check_val("R6", result, ref_swap(64'h1122_3344_5566_7788, s));
    end
    // R7 population count
    run_op(3'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0); check_val("R7", result, 64'd64);
    run_op(3'd3, 8, 64'h8000_0000_0000_0001, 0); check_val("R7", result, 64'd2);
    run_op(3'd3, 8, 64'd0, 0); check_val("R7", result, 64'd0);
    // R8 bit test
    run_op(3'd4, 8, 64'hC0, 64'h0F);
    check_val("R8", {60'd0, flag_n, flag_v, flag_z, result_we}, 64'b1110);
    run_op(3'd4, 8, 64'h41, 64'hFF);
    check_val("R8", {60'd0, flag_n, flag_v, flag_z, result_we}, 64'b0100);
    // R9 reserved codes
    for (int o = 5; o < 8; o++) begin
      run_op(3'(o), 8, 64'hFFFF, 64'hFFFF);
      check_val("R9", {59'd0, done, result_we, flag_z_we, flag_n_we, flag_v_we}, 64'b10000);
    end
    // R11 idle gap keeps values, enables low
    @(negedge clk);
    check_val("R11", {62'd0, done, result_we}, 64'd0);
    // R1 back-to-back starts, compared every cycle by the model
    @(negedge clk);
    for (int k = 0; k < 300; k++) begin
      op = 3'($urandom_range(0, 7));
      size = 4'($urandom_range(0, 15));
      operand = {$urandom, $urandom};
      if (k % 5 == 0) operand = operand >> $urandom_range(0, 63);
      acc = {$urandom, $urandom};
      start = ($urandom_range(0, 3) != 0);
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule